// File: doc/BRIEF.md
# Host Bridge Window Configuration Registers

This block is the software-visible configuration store of a host bridge. It holds, for each of four address windows, a base register, a mask register and a translated-base register, plus one bridge control register. All of them are driven continuously to the address translator next to it. A processor reaches the block through a simple single-cycle strobe interface. The interface carries a byte offset into a 4 KB region, a write flag, a size code, 64-bit write data, registered read data and an error flag.

Registers sit on a 64-byte stride, so the register index is the offset shifted right by six. A few locations are kept only so that software does not trap. The error-status and invalidate-all locations read as zero and silently drop writes. The error-mask location reads as zero but rejects writes. Every other index is unsupported and answers with the error flag. Any access that is not a full 64-bit access also answers with the error flag.

Top module: `hb_cfg_regs`

## Requirements
- R1: After reset every window base, mask and translated-base register is zero, and the control register holds 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in bits 39:36).
- R2: The register index is addr_i[11:6], and addr_i[5:0] is ignored. The window base registers of windows 0-3 are at indices 0-3, the mask registers at indices 4-7 and the translated-base registers at indices 8-11.
- R3: The window registers are fully read/write. A write updates the register on the clock edge of its strobe, and the new value appears on win_base_o, win_mask_o or xlat_base_o right after that edge. Window n occupies bits [64n+63:64n] of each of these ports.
- R4: The control register is at index 12 and is fully read/write. ctrl_o changes only on an accepted write to index 12.
- R5: Read data and the error flag are registered and appear in the cycle after the strobe. rdata_o is zero in every cycle that does not follow an accepted read.
- R6: Index 15 (error status) and index 19 (invalidate all) read as zero without error. Writes to them are accepted without error and change no register.
- R7: Index 16 (error mask) reads as zero without error. A write to it gets the error response.
- R8: Indices 13, 14, 17, 18, 20, 21 and every index from 22 to 63 are unsupported. A read or write to one of them gets the error response, returns zero read data and changes no register.
- R9: size_i encodes the access width as log2 of the byte count, and only 3 (64 bits) is legal. Any other size gets the error response and changes no register, whatever the index.
- R10: err_o is high for exactly the one cycle after a rejected strobe and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset into the register region |
| size_i | input | 2 | Access size, log2 of byte count |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| err_o | output | 1 | Registered error response |
| win_base_o | output | 256 | Window base registers, window n at [64n+63:64n] |
| win_mask_o | output | 256 | Window mask registers |
| xlat_base_o | output | 256 | Translated-base registers |
| ctrl_o | output | 64 | Bridge control register |

## Verification
Each register class gets a write followed by a readback with a data pattern distinct from the others. This shows that a write lands in exactly one of the twelve window slots and not in its neighbour. An offset with nonzero low bits shows that only the upper six address bits select the register. Reads and writes to the zero and ignore locations are set against the unsupported indices, against the write-rejecting mask location and against short accesses. This separates "accepted, no effect" from "rejected". A final readback of every written register, together with the translator ports, shows that no rejected or ignored access changed any state.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;
  typedef enum logic [2:0] {
    CLS_WBASE,
    CLS_WMASK,
    CLS_XBASE,
    CLS_CTRL,
    CLS_RAZ_WI,   // read zero, write dropped
    CLS_RAZ_WERR, // read zero, write rejected
    CLS_BAD
  } acc_cls_e;

  localparam logic [1:0] SIZE_64 = 2'd3;
  localparam logic [63:0] CTRL_RST = (64'h1 << 20) | (64'h1 << 32) | (64'h2 << 36);

  // index layout derived from window count
  function automatic int idx_ctrl(int nw);    return 3 * nw;     endfunction
  function automatic int idx_errstat(int nw); return 3 * nw + 3; endfunction
  function automatic int idx_errmask(int nw); return 3 * nw + 4; endfunction
  function automatic int idx_invall(int nw);  return 3 * nw + 7; endfunction
endpackage

// File: rtl/hb_cfg_decode.sv
module hb_cfg_decode
  import hb_cfg_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IW      = 6,
  localparam int SW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [IW-1:0] idx_i,
  output acc_cls_e      cls_o,
  output logic [SW-1:0] sel_o
);
  always_comb begin
    int i;
    i = int'(idx_i);
    cls_o = CLS_BAD;
    sel_o = '0;
    if (i < NUM_WIN) begin
      cls_o = CLS_WBASE;
      sel_o = SW'(i);
    end else if (i < 2 * NUM_WIN) begin
      cls_o = CLS_WMASK;
      sel_o = SW'(i - NUM_WIN);
    end else if (i < 3 * NUM_WIN) begin
      cls_o = CLS_XBASE;
      sel_o = SW'(i - 2 * NUM_WIN);
    end else if (i == idx_ctrl(NUM_WIN)) begin
      cls_o = CLS_CTRL;
    end else if (i == idx_errstat(NUM_WIN) || i == idx_invall(NUM_WIN)) begin
      cls_o = CLS_RAZ_WI;
    end else if (i == idx_errmask(NUM_WIN)) begin
      cls_o = CLS_RAZ_WERR;
    end
  end
endmodule

// File: rtl/hb_cfg_store.sv
module hb_cfg_store
  import hb_cfg_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DW      = 64,
  parameter logic [DW-1:0] CTRL_INIT = CTRL_RST,
  localparam int SW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  acc_cls_e      cls_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] base_o [NUM_WIN],
  output logic [DW-1:0] mask_o [NUM_WIN],
  output logic [DW-1:0] xbase_o[NUM_WIN],
  output logic [DW-1:0] ctrl_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit;
    assign hit = wr_i && (sel_i == SW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[w]  <= '0;
        mask_o[w]  <= '0;
        xbase_o[w] <= '0;
      end else if (hit) begin
        if (cls_i == CLS_WBASE) base_o[w]  <= wdata_i;
        if (cls_i == CLS_WMASK) mask_o[w]  <= wdata_i;
        if (cls_i == CLS_XBASE) xbase_o[w] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_o <= CTRL_INIT;
    else if (wr_i && cls_i == CLS_CTRL) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs
  import hb_cfg_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int DW        = 64,
  parameter int AW        = 12,
  parameter int STRIDE_LG = 6,
  localparam int IW       = AW - STRIDE_LG,
  localparam int SW       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [1:0]            size_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  err_o,
  output logic [NUM_WIN*DW-1:0] win_base_o,
  output logic [NUM_WIN*DW-1:0] win_mask_o,
  output logic [NUM_WIN*DW-1:0] xlat_base_o,
  output logic [DW-1:0]         ctrl_o
);
  acc_cls_e      cls;
  logic [SW-1:0] sel;
  logic          bad, wr_ok, rd_ok;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] base [NUM_WIN];
  logic [DW-1:0] mask [NUM_WIN];
  logic [DW-1:0] xbase[NUM_WIN];
  logic [DW-1:0] ctrl;

  hb_cfg_decode #(.NUM_WIN(NUM_WIN), .IW(IW)) i_decode (
    .idx_i(addr_i[AW-1:STRIDE_LG]),
    .cls_o(cls),
    .sel_o(sel)
  );

  assign bad   = (size_i != SIZE_64) || (cls == CLS_BAD) || (we_i && cls == CLS_RAZ_WERR);
  assign wr_ok = req_i && we_i && !bad;
  assign rd_ok = req_i && !we_i && !bad;

  hb_cfg_store #(.NUM_WIN(NUM_WIN), .DW(DW), .CTRL_INIT(DW'(CTRL_RST))) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_ok),
    .cls_i  (cls),
    .sel_i  (sel),
    .wdata_i(wdata_i),
    .base_o (base),
    .mask_o (mask),
    .xbase_o(xbase),
    .ctrl_o (ctrl)
  );

  always_comb begin
    unique case (cls)
      CLS_WBASE: rd_val = base[sel];
      CLS_WMASK: rd_val = mask[sel];
      CLS_XBASE: rd_val = xbase[sel];
      CLS_CTRL:  rd_val = ctrl;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? rd_val : '0;
      err_o   <= req_i && bad;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_flat
    assign win_base_o [w*DW +: DW] = base[w];
    assign win_mask_o [w*DW +: DW] = mask[w];
    assign xlat_base_o[w*DW +: DW] = xbase[w];
  end
  assign ctrl_o = ctrl;
endmodule

// File: rtl/hb_cfg_regs_chk.sv
module hb_cfg_regs_chk
  import hb_cfg_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int DW        = 64,
  parameter int AW        = 12,
  parameter int STRIDE_LG = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [AW-1:0]         addr_i,
  input logic [1:0]            size_i,
  input logic [DW-1:0]         wdata_i,
  input logic [DW-1:0]         rdata_o,
  input logic                  err_o,
  input logic [NUM_WIN*DW-1:0] win_base_o,
  input logic [NUM_WIN*DW-1:0] win_mask_o,
  input logic [NUM_WIN*DW-1:0] xlat_base_o,
  input logic [DW-1:0]         ctrl_o
);
  localparam int IW = AW - STRIDE_LG;
  int idx;
  logic full, rd, wr;
  assign idx  = int'(addr_i[AW-1:STRIDE_LG]);
  assign full = size_i == SIZE_64;
  assign rd   = req_i && !we_i;
  assign wr   = req_i && we_i;

  // R3: write to window 0 base shows on the port after the edge
  p_wbase_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && full && idx == 0 |=> win_base_o[DW-1:0] == $past(wdata_i));

  // R4: control changes only on a write strobe
  p_ctrl_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ctrl_o));

  // R5: read data is zero unless a read was strobed
  p_rdata_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> rdata_o == '0);

  // R6: zero-read locations answer zero without error
  p_raz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && full && (idx == idx_errstat(NUM_WIN) || idx == idx_invall(NUM_WIN))
    |=> rdata_o == '0 && !err_o);

  // R8: unsupported index errors
  p_unsup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && idx > idx_ctrl(NUM_WIN) + 9 |=> err_o);

  // R9: short access errors and leaves state alone
  p_short_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !full |=> err_o && $stable(win_base_o) && $stable(win_mask_o)
                       && $stable(xlat_base_o) && $stable(ctrl_o));

  // R10: error only after a strobe
  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
endmodule

bind hb_cfg_regs hb_cfg_regs_chk #(
  .NUM_WIN(NUM_WIN), .DW(DW), .AW(AW), .STRIDE_LG(STRIDE_LG)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
  .win_base_o(win_base_o), .win_mask_o(win_mask_o), .xlat_base_o(xlat_base_o),
  .ctrl_o(ctrl_o)
);

// File: tb/test_hb_cfg_regs.sv
module test_hb_cfg_regs;
  localparam logic [63:0] CTRL_INIT = 64'h0000_0021_0010_0000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [11:0]  addr = '0;
  logic [1:0]   size = 2'd3;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic         err;
  logic [255:0] wbase, wmask, xbase;
  logic [63:0]  ctrl;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  hb_cfg_regs i_hb_cfg_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .win_base_o(wbase), .win_mask_o(wmask), .xlat_base_o(xbase), .ctrl_o(ctrl)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        we;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [63:0] wd;
    logic [63:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 1'b1, 12'h040, 2'd3, 64'hA5A5_0000_1111_0001, 64'h0, 1'b0}, // R3 base1
    '{4'd3, 1'b0, 12'h040, 2'd3, 64'h0, 64'hA5A5_0000_1111_0001, 1'b0},
    '{4'd2, 1'b1, 12'h18C, 2'd3, 64'h0FF0_2222_3333_0006, 64'h0, 1'b0}, // R2 mask2, low bits set
    '{4'd2, 1'b0, 12'h1B1, 2'd3, 64'h0, 64'h0FF0_2222_3333_0006, 1'b0},
    '{4'd3, 1'b1, 12'h2C0, 2'd3, 64'h1234_5678_9ABC_000B, 64'h0, 1'b0}, // R3 xlat3
    '{4'd3, 1'b0, 12'h2C0, 2'd3, 64'h0, 64'h1234_5678_9ABC_000B, 1'b0},
    '{4'd4, 1'b1, 12'h300, 2'd3, 64'hDEAD_BEEF_0000_000C, 64'h0, 1'b0}, // R4 ctrl
    '{4'd4, 1'b0, 12'h300, 2'd3, 64'h0, 64'hDEAD_BEEF_0000_000C, 1'b0},
    '{4'd6, 1'b1, 12'h3C0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}, // R6 err status
    '{4'd6, 1'b0, 12'h3C0, 2'd3, 64'h0, 64'h0, 1'b0},
    '{4'd6, 1'b1, 12'h4C0, 2'd3, 64'h5555_5555_5555_5555, 64'h0, 1'b0}, // R6 inval all
    '{4'd6, 1'b0, 12'h4C0, 2'd3, 64'h0, 64'h0, 1'b0},
    '{4'd7, 1'b0, 12'h400, 2'd3, 64'h0, 64'h0, 1'b0},                   // R7 err mask
    '{4'd7, 1'b1, 12'h400, 2'd3, 64'h7777_7777_7777_7777, 64'h0, 1'b1},
    '{4'd8, 1'b0, 12'h340, 2'd3, 64'h0, 64'h0, 1'b1},                   // R8 idx13
    '{4'd8, 1'b1, 12'h500, 2'd3, 64'h9999_9999_9999_9999, 64'h0, 1'b1}, // R8 idx20
    '{4'd8, 1'b1, 12'h440, 2'd3, 64'h8888_8888_8888_8888, 64'h0, 1'b1}, // R8 idx17
    '{4'd8, 1'b0, 12'hFC0, 2'd3, 64'h0, 64'h0, 1'b1},                   // R8 idx63
    '{4'd9, 1'b0, 12'h040, 2'd2, 64'h0, 64'h0, 1'b1},                   // R9 short read
    '{4'd9, 1'b1, 12'h300, 2'd0, 64'h4444_4444_4444_4444, 64'h0, 1'b1}  // R9 short write
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] s,
                        input logic [63:0] d, output logic [63:0] rd, output logic er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd = rdata; er = err;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        er;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values through the bus and the ports
    for (int i = 0; i < 12; i++) begin
      access(1'b0, 12'(i << 6), 2'd3, '0, rd, er);
      check("R1 window reset", rd, 64'h0);
    end
    access(1'b0, 12'h300, 2'd3, '0, rd, er);
    check("R1 ctrl reset read", rd, CTRL_INIT);
    check("R1 ctrl_o reset", ctrl, CTRL_INIT);

    // table walk
    for (int v = 0; v < NV; v++) begin
      access(VECS[v].we, VECS[v].addr, VECS[v].size, VECS[v].wd, rd, er);
      check($sformatf("R%0d vec%0d rdata", VECS[v].tag, v), rd, VECS[v].exp_rd);
      check($sformatf("R%0d vec%0d err", VECS[v].tag, v), {63'h0, er}, {63'h0, VECS[v].exp_err});
    end

    // R10 / R5: idle cycle after an error: no error, zero data
    @(negedge clk);
    check("R10 err low when idle", {63'h0, err}, 64'h0);
    check("R5 rdata zero when idle", rdata, 64'h0);

    // R3 window write reaches translator port right after the edge
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h000; size = 2'd3; wdata = 64'hC0DE_0000_0000_0100;
    @(posedge clk); #1;
    check("R3 win_base_o after edge", wbase[63:0], 64'hC0DE_0000_0000_0100);
    @(negedge clk); req = 1'b0; we = 1'b0;

    // R5 read data registered: not present before the edge
    @(negedge clk);
    req = 1'b1; addr = 12'h000; #2;
    check("R5 rdata before edge", rdata, 64'h0);
    @(negedge clk); req = 1'b0;
    check("R5 rdata after edge", rdata, 64'hC0DE_0000_0000_0100);

    // R6/R7/R8/R9: nothing changed by ignored or rejected writes
    check("R9 ctrl unchanged", ctrl, 64'hDEAD_BEEF_0000_000C);
    check("R8 base1 unchanged", wbase[127:64], 64'hA5A5_0000_1111_0001);
    check("R2 mask2 port", wmask[191:128], 64'h0FF0_2222_3333_0006);
    check("R6 mask0 untouched", wmask[63:0], 64'h0);
    check("R3 xlat3 port", xbase[255:192], 64'h1234_5678_9ABC_000B);
    check("R8 xlat0 untouched", xbase[63:0], 64'h0);
    access(1'b0, 12'h040, 2'd3, '0, rd, er);
    check("R9 base1 readback", rd, 64'hA5A5_0000_1111_0001);

    // R1 reset mid-run restores control pattern
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R1 ctrl after reset", ctrl, CTRL_INIT);
    check("R1 base after reset", wbase[63:0], 64'h0);
    rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule